// File: doc/BRIEF.md
# Shared Coax Port Direction Sequencer

This controller sits in host logic next to a bidirectional video port device whose single coaxial connection can act as an equalizing receiver or as a cable driver. On a mode request it walks through the pin changes and serial register writes that each direction needs, in the order the device requires. It drives the device's transmit-enable and serial-access-enable pins, and it is the master of the device's four-wire serial control bus. A requested mode is applied through a start strobe. The controller reports busy while a sequence runs and pulses done when the sequence ends.

Three modes exist. Receive turns the driver off before it wakes the equalizer and loads the mandatory nominal launch tuning value. Normal transmit forces the equalizer to sleep before it turns the driver on. Loopback transmit wakes and tunes the equalizer, then turns the driver on. The controller remembers when the equalizer is already awake and tuned with the requested sleep code. In that case a later change between receive and loopback transmit only toggles the transmit-enable pin and sends no serial frames. An optional status poll reads two device registers and holds the carrier indication and a cable length code on registered outputs.

Top module: `port_mode_seq`

## Requirements
- R1: After reset, tx_en_o, spi_en_o, sck_o, mosi_o, mosi_oe_o, busy_o and done_o are low and ss_n_o is high.
- R2: mode_i encodings are 00 receive, 01 normal transmit, 10 loopback transmit. A receive request that cannot take the shortcut first drives tx_en_o low, then writes frame 16'h0008 (16'h0000 when never_sleep_i is 1), then writes frame 16'h0230. tx_en_o stays low during both frames.
- R3: A normal transmit request writes frame 16'h0010 with tx_en_o unchanged, then drives tx_en_o high. It also clears the record that the equalizer is awake.
- R4: A loopback request that cannot take the shortcut writes the sleep frame (16'h0008 or 16'h0000), then frame 16'h0230, then drives tx_en_o high.
- R5: After a receive or loopback sequence, a later receive or loopback request with the same sleep code sends no frame and only sets tx_en_o (low for receive, high for loopback). A different sleep code, or any request made after a normal transmit, runs the full sequence.
- R6: spi_en_o goes high on the first accepted request and never returns low. ss_n_o is low only while spi_en_o is high.
- R7: Each frame is 16 bits sent MSB first, with bit 15 the read flag, bits 14:8 the register address and bits 7:0 the data. MOSI is sampled on rising SCK edges, SCK idles low while SS is high, and each frame has exactly 16 rising edges.
- R8: SCK high and low phases each last at least SCK_HALF clock cycles, and rising edges within a frame are 2*SCK_HALF cycles apart. SS stays high for at least SS_GAP cycles between frames. MOSI does not change while SCK is high.
- R9: In a read frame (bit 15 = 1), mosi_oe_o is low at every rising edge after the eighth. MISO is sampled MSB first on rising edges 9 to 16.
- R10: A pulse on poll_i while idle sends read frames 16'h8000 and then 16'h8300. carrier_o then shows bit 0 of the first byte read, cable_len_o shows bits 4:0 of the second, and tx_en_o is not changed.
- R11: A request is accepted only while busy_o is low. Requests during busy, and mode 11, are ignored. done_o is a single-cycle pulse with busy_o low, issued once the last step of a sequence has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Mode request strobe |
| mode_i | input | 2 | Requested mode: 00 receive, 01 transmit, 10 loopback |
| never_sleep_i | input | 1 | Selects the never-sleep code instead of auto sleep |
| poll_i | input | 1 | Status poll strobe |
| miso_i | input | 1 | Serial data from device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tx_en_o | output | 1 | Cable driver enable pin |
| spi_en_o | output | 1 | Device serial access enable pin |
| ss_n_o | output | 1 | Serial slave select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to device |
| mosi_oe_o | output | 1 | Drive enable for the MOSI pad |
| carrier_o | output | 1 | Polled carrier indication |
| cable_len_o | output | 5 | Polled cable length code |

## Verification
The assertions assume that the device answers read frames only after the eighth rising SCK edge. They also assume that the host pulses start_i or poll_i for single cycles, so no request stays asserted across the cycle in which busy falls. The bench's slave model drives MISO only on falling SCK edges of the data half of a read frame. All stimulus is applied on the falling system clock edge, so requests made during a sequence reach the design only as the ignored strobes that R11 describes.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;
   localparam int FRAME_W = 16;
   localparam int DATA_W  = 8;
   localparam int CMD_W   = FRAME_W - DATA_W;

   typedef enum logic [1:0] {
      MODE_RX   = 2'b00,
      MODE_TX   = 2'b01,
      MODE_LOOP = 2'b10,
      MODE_RSVD = 2'b11
   } mode_e;

   typedef enum logic [2:0] {
      STEP_END,
      STEP_PIN_LO,
      STEP_PIN_HI,
      STEP_WR_SLEEP,
      STEP_WR_TUNE,
      STEP_RD_STAT,
      STEP_RD_LEN
   } step_e;

   localparam logic [6:0] ADDR_CTRL = 7'h00;
   localparam logic [6:0] ADDR_TUNE = 7'h02;
   localparam logic [6:0] ADDR_LEN  = 7'h03;

   localparam logic [7:0] TUNE_NOMINAL = 8'h30;
   localparam logic [7:0] SLEEP_AUTO   = 8'h08;
   localparam logic [7:0] SLEEP_NEVER  = 8'h00;
   localparam logic [7:0] SLEEP_FORCE  = 8'h10;

   function automatic logic [FRAME_W-1:0] wr_word(input logic [6:0] a, input logic [7:0] d);
      return {1'b0, a, d};
   endfunction

   function automatic logic [FRAME_W-1:0] rd_word(input logic [6:0] a);
      return {1'b1, a, 8'h00};
   endfunction
endpackage

// File: rtl/pms_spi_master.sv
`timescale 1ns/1ps
module pms_spi_master
   import pms_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int GAP_CYC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_i,
   input  logic [FRAME_W-1:0] word_i,
   input  logic               read_i,
   input  logic               miso_i,
   output logic               ss_n_o,
   output logic               sck_o,
   output logic               mosi_o,
   output logic               mosi_oe_o,
   output logic               done_o,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int MAXC = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int BW   = $clog2(FRAME_W);
   localparam logic [CW-1:0] HALF_END = CW'(HALF_CYC - 1);
   localparam logic [CW-1:0] GAP_END  = CW'(GAP_CYC - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
   localparam logic [BW-1:0] CMD_LAST = BW'(CMD_W - 1);

   typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_GAP} sp_t;

   sp_t                st;
   logic [CW-1:0]      cnt;
   logic [BW-1:0]      bitn;
   logic [FRAME_W-1:0] shreg;
   logic               rd;

   assign mosi_o = shreg[FRAME_W-1] & mosi_oe_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         shreg     <= '0;
         rd        <= 1'b0;
         ss_n_o    <= 1'b1;
         sck_o     <= 1'b0;
         mosi_oe_o <= 1'b0;
         done_o    <= 1'b0;
         rdata_o   <= '0;
      end else begin
         done_o <= 1'b0;
         case (st)
            S_IDLE: begin
               if (go_i) begin
                  shreg     <= word_i;
                  rd        <= read_i;
                  ss_n_o    <= 1'b0;
                  mosi_oe_o <= 1'b1;
                  cnt       <= '0;
                  bitn      <= '0;
                  st        <= S_LEAD;
               end
            end
            S_LEAD: begin
               if (cnt == HALF_END) begin
                  cnt   <= '0;
                  sck_o <= 1'b1;
                  st    <= S_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_HIGH: begin
               if (cnt == HALF_END) begin
                  cnt   <= '0;
                  sck_o <= 1'b0;
                  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  if (rd && bitn == CMD_LAST) mosi_oe_o <= 1'b0;
                  st    <= S_LOW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_LOW: begin
               if (cnt == HALF_END) begin
                  cnt <= '0;
                  if (bitn == LAST_BIT) begin
                     ss_n_o    <= 1'b1;
                     mosi_oe_o <= 1'b0;
                     st        <= S_GAP;
                  end else begin
                     bitn  <= bitn + 1'b1;
                     sck_o <= 1'b1;
                     if (rd && bitn >= CMD_LAST)
                        rdata_o <= {rdata_o[DATA_W-2:0], miso_i};
                     st    <= S_HIGH;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_GAP: begin
               if (cnt == GAP_END) begin
                  cnt    <= '0;
                  done_o <= 1'b1;
                  st     <= S_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pms_sequencer.sv
`timescale 1ns/1ps
module pms_sequencer
   import pms_pkg::*;
#(
   parameter bit POLL_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         mode_i,
   input  logic               never_sleep_i,
   input  logic               poll_i,
   input  logic               spi_done_i,
   output logic               spi_go_o,
   output logic [FRAME_W-1:0] spi_word_o,
   output logic               spi_read_o,
   output logic               tx_en_o,
   output logic               spi_en_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               stat_we_o,
   output logic               len_we_o
);
   localparam int NSTEP = 4;

   typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_WAIT} q_t;

   q_t         q;
   step_e      prog [NSTEP];
   step_e      np   [NSTEP];
   logic [1:0] idx;
   logic [7:0] sleep_q, sleep_req, eq_code;
   logic       eq_ready, is_poll, is_tx;
   logic       accept_mode, accept_poll, shortcut;
   mode_e      mode_in;

   assign mode_in     = mode_e'(mode_i);
   assign accept_mode = (q == Q_IDLE) && start_i && (mode_in != MODE_RSVD);
   assign accept_poll = POLL_EN && (q == Q_IDLE) && !start_i && poll_i;
   assign sleep_req   = (mode_in == MODE_TX) ? SLEEP_FORCE :
                        (never_sleep_i ? SLEEP_NEVER : SLEEP_AUTO);
   assign shortcut    = eq_ready && (eq_code == sleep_req);
   assign busy_o      = (q != Q_IDLE);

   always_comb begin
      np = '{STEP_END, STEP_END, STEP_END, STEP_END};
      if (accept_poll) begin
         np = '{STEP_RD_STAT, STEP_RD_LEN, STEP_END, STEP_END};
      end else begin
         case (mode_in)
            MODE_RX:
               if (shortcut) np[0] = STEP_PIN_LO;
               else np = '{STEP_PIN_LO, STEP_WR_SLEEP, STEP_WR_TUNE, STEP_END};
            MODE_LOOP:
               if (shortcut) np[0] = STEP_PIN_HI;
               else np = '{STEP_WR_SLEEP, STEP_WR_TUNE, STEP_PIN_HI, STEP_END};
            MODE_TX:
               np = '{STEP_WR_SLEEP, STEP_PIN_HI, STEP_END, STEP_END};
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q          <= Q_IDLE;
         prog       <= '{STEP_END, STEP_END, STEP_END, STEP_END};
         idx        <= '0;
         sleep_q    <= '0;
         eq_code    <= '0;
         eq_ready   <= 1'b0;
         is_poll    <= 1'b0;
         is_tx      <= 1'b0;
         spi_go_o   <= 1'b0;
         spi_word_o <= '0;
         spi_read_o <= 1'b0;
         tx_en_o    <= 1'b0;
         spi_en_o   <= 1'b0;
         done_o     <= 1'b0;
         stat_we_o  <= 1'b0;
         len_we_o   <= 1'b0;
      end else begin
         spi_go_o  <= 1'b0;
         done_o    <= 1'b0;
         stat_we_o <= 1'b0;
         len_we_o  <= 1'b0;
         case (q)
            Q_IDLE: begin
               if (accept_mode || accept_poll) begin
                  prog     <= np;
                  idx      <= '0;
                  sleep_q  <= sleep_req;
                  is_poll  <= accept_poll;
                  is_tx    <= (mode_in == MODE_TX);
                  spi_en_o <= 1'b1;
                  q        <= Q_RUN;
               end
            end
            Q_RUN: begin
               case (prog[idx])
                  STEP_END: begin
                     done_o <= 1'b1;
                     q      <= Q_IDLE;
                     if (!is_poll) begin
                        eq_ready <= !is_tx;
                        eq_code  <= sleep_q;
                     end
                  end
                  STEP_PIN_LO: begin
                     tx_en_o <= 1'b0;
                     idx     <= idx + 1'b1;
                  end
                  STEP_PIN_HI: begin
                     tx_en_o <= 1'b1;
                     idx     <= idx + 1'b1;
                  end
                  default: begin
                     spi_go_o <= 1'b1;
                     q        <= Q_WAIT;
                     case (prog[idx])
                        STEP_WR_SLEEP: begin
                           spi_word_o <= wr_word(ADDR_CTRL, sleep_q);
                           spi_read_o <= 1'b0;
                        end
                        STEP_WR_TUNE: begin
                           spi_word_o <= wr_word(ADDR_TUNE, TUNE_NOMINAL);
                           spi_read_o <= 1'b0;
                        end
                        STEP_RD_STAT: begin
                           spi_word_o <= rd_word(ADDR_CTRL);
                           spi_read_o <= 1'b1;
                        end
                        default: begin
                           spi_word_o <= rd_word(ADDR_LEN);
                           spi_read_o <= 1'b1;
                        end
                     endcase
                  end
               endcase
            end
            Q_WAIT: begin
               if (spi_done_i) begin
                  stat_we_o <= (prog[idx] == STEP_RD_STAT);
                  len_we_o  <= (prog[idx] == STEP_RD_LEN);
                  idx       <= idx + 1'b1;
                  q         <= Q_RUN;
               end
            end
            default: q <= Q_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/port_mode_seq.sv
`timescale 1ns/1ps
module port_mode_seq
   import pms_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SCK_HALF    = 2,
   parameter int SS_GAP      = 2,
   parameter bit POLL_EN     = 1'b1,
   parameter int CARRIER_BIT = 0,
   parameter int LEN_BITS    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [1:0]          mode_i,
   input  logic                never_sleep_i,
   input  logic                poll_i,
   input  logic                miso_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                tx_en_o,
   output logic                spi_en_o,
   output logic                ss_n_o,
   output logic                sck_o,
   output logic                mosi_o,
   output logic                mosi_oe_o,
   output logic                carrier_o,
   output logic [LEN_BITS-1:0] cable_len_o
);
   localparam longint SCK_MAX_HZ  = 20_000_000;
   localparam longint GAP_MIN_NS  = 10;
   localparam longint SCK_HZ      = longint'(CLK_HZ) / (2 * longint'(SCK_HALF));

   if (SCK_HALF < 1) begin : g_chk_half
      $error("SCK_HALF must be at least 1");
   end
   if (SCK_HZ > SCK_MAX_HZ) begin : g_chk_rate
      $error("SCK rate above 20 MHz");
   end
   if (longint'(SS_GAP) * 64'd1_000_000_000 < GAP_MIN_NS * longint'(CLK_HZ)) begin : g_chk_gap
      $error("SS high time below 10 ns");
   end
   if (LEN_BITS > DATA_W || CARRIER_BIT >= DATA_W) begin : g_chk_fields
      $error("status field outside the data byte");
   end

   logic               spi_go, spi_read, spi_done, stat_we, len_we;
   logic [FRAME_W-1:0] spi_word;
   logic [DATA_W-1:0]  spi_rdata;

   pms_sequencer #(.POLL_EN(POLL_EN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .mode_i        (mode_i),
      .never_sleep_i (never_sleep_i),
      .poll_i        (poll_i),
      .spi_done_i    (spi_done),
      .spi_go_o      (spi_go),
      .spi_word_o    (spi_word),
      .spi_read_o    (spi_read),
      .tx_en_o       (tx_en_o),
      .spi_en_o      (spi_en_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .stat_we_o     (stat_we),
      .len_we_o      (len_we)
   );

   pms_spi_master #(.HALF_CYC(SCK_HALF), .GAP_CYC(SS_GAP)) u_spi (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (spi_go),
      .word_i    (spi_word),
      .read_i    (spi_read),
      .miso_i    (miso_i),
      .ss_n_o    (ss_n_o),
      .sck_o     (sck_o),
      .mosi_o    (mosi_o),
      .mosi_oe_o (mosi_oe_o),
      .done_o    (spi_done),
      .rdata_o   (spi_rdata)
   );

   if (POLL_EN) begin : g_poll
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            carrier_o   <= 1'b0;
            cable_len_o <= '0;
         end else begin
            if (stat_we) carrier_o   <= spi_rdata[CARRIER_BIT];
            if (len_we)  cable_len_o <= spi_rdata[LEN_BITS-1:0];
         end
      end
   end else begin : g_nopoll
      logic unused_poll;
      assign unused_poll = ^{stat_we, len_we, spi_rdata};
      assign carrier_o   = 1'b0;
      assign cable_len_o = '0;
   end
endmodule

// File: rtl/pms_checker.sv
`timescale 1ns/1ps
module pms_checker #(
   parameter int HALF_CYC = 2,
   parameter int GAP_CYC  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic tx_en_o,
   input logic spi_en_o,
   input logic ss_n_o,
   input logic sck_o,
   input logic mosi_o
);
   localparam logic [15:0] SAT = 16'hFFFF;
   logic [15:0] hi_len, lo_len, ss_hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len    <= '0;
         lo_len    <= '0;
         ss_hi_len <= '0;
      end else begin
         hi_len    <= sck_o  ? ((hi_len == SAT) ? SAT : hi_len + 1'b1) : '0;
         lo_len    <= !sck_o ? ((lo_len == SAT) ? SAT : lo_len + 1'b1) : '0;
         ss_hi_len <= ss_n_o ? ((ss_hi_len == SAT) ? SAT : ss_hi_len + 1'b1) : '0;
      end
   end

   p_ss_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n_o |-> spi_en_o);
   p_en_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en_o |=> spi_en_o);
   p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_o |-> !sck_o);
   p_high_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck_o) |-> (hi_len >= 16'(HALF_CYC)));
   p_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> (lo_len >= 16'(HALF_CYC)));
   p_ss_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ss_n_o) |-> (ss_hi_len >= 16'(GAP_CYC)));
   p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> $stable(mosi_o));
   p_pin_quiet_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n_o |-> $stable(tx_en_o));
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

bind port_mode_seq pms_checker #(.HALF_CYC(SCK_HALF), .GAP_CYC(SS_GAP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .tx_en_o  (tx_en_o),
   .spi_en_o (spi_en_o),
   .ss_n_o   (ss_n_o),
   .sck_o    (sck_o),
   .mosi_o   (mosi_o)
);

// File: tb/port_mode_seq_tb.sv
`timescale 1ns/1ps
module port_mode_seq_tb;
   localparam int CLK_NS = 20;
   localparam int HALF   = 2;
   localparam int GAP    = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic       never_sleep_i = 1'b0;
   logic       poll_i = 1'b0;
   logic       miso_i = 1'b0;
   logic       busy_o, done_o, tx_en_o, spi_en_o, ss_n_o, sck_o, mosi_o, mosi_oe_o, carrier_o;
   logic [4:0] cable_len_o;

   port_mode_seq #(.CLK_HZ(50_000_000), .SCK_HALF(HALF), .SS_GAP(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .never_sleep_i(never_sleep_i), .poll_i(poll_i), .miso_i(miso_i),
      .busy_o(busy_o), .done_o(done_o), .tx_en_o(tx_en_o), .spi_en_o(spi_en_o),
      .ss_n_o(ss_n_o), .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
      .carrier_o(carrier_o), .cable_len_o(cable_len_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rid, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
      end
   endtask

   // slave model and frame log
   bit          log_on = 1'b0;
   int          sl_cnt = 0;
   logic [15:0] sl_sh = '0;
   logic        sl_rd = 1'b0;
   logic [7:0]  sl_resp = '0;
   logic [7:0]  stat_val = '0;
   logic [7:0]  len_val = '0;
   time         last_rise = 0;
   int          tim_err = 0, oe_err = 0, len_err = 0, n_fr = 0;
   logic [15:0] fr_w [8];
   logic        fr_tx [8];

   always @(negedge ss_n_o) begin
      sl_cnt = 0;
      sl_sh  = '0;
   end

   always @(posedge sck_o) begin
      if (log_on && !ss_n_o) begin
         if (sl_cnt > 0 && ($time - last_rise) != time'(2*HALF*CLK_NS)) tim_err++;
         last_rise = $time;
         if (sl_cnt == 0) sl_rd = mosi_o;
         if (sl_cnt >= 8 && sl_rd && mosi_oe_o) oe_err++;
         sl_sh = {sl_sh[14:0], mosi_o};
         sl_cnt++;
         if (sl_cnt == 8) sl_resp = (sl_sh[6:0] == 7'h03) ? len_val : stat_val;
      end
   end

   always @(negedge sck_o) begin
      if (log_on && !ss_n_o && sl_rd && sl_cnt >= 8 && sl_cnt < 16)
         miso_i = sl_resp[15-sl_cnt];
   end

   always @(posedge ss_n_o) begin
      if (log_on) begin
         if (sl_cnt != 16) len_err++;
         if (n_fr < 8) begin
            fr_w[n_fr]  = sl_sh;
            fr_tx[n_fr] = tx_en_o;
         end
         n_fr++;
      end
   end

   // reference model of the controller state
   bit         m_ready = 1'b0;
   logic [7:0] m_code = '0;
   bit         m_tx = 1'b0;

   task automatic clear_log();
      n_fr = 0; tim_err = 0; oe_err = 0; len_err = 0;
   endtask

   task automatic wait_done(input string rid);
      bit got = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         if (done_o) begin got = 1'b1; break; end
         @(negedge clk);
      end
      chk(got, rid, 32'(got), 32'd1);
      chk(!busy_o, "R11 busy low with done", 32'(busy_o), 32'd0);
      @(negedge clk);
      chk(!done_o, "R11 done single cycle", 32'(done_o), 32'd0);
   endtask

   task automatic do_op(input int m, input bit ns, input bit poke);
      logic [7:0]  code;
      bit          shortc;
      int          exp_n;
      logic [15:0] ew [2];
      bit          etx_fr, etx_end;
      string       rid;
      code   = (m == 1) ? 8'h10 : (ns ? 8'h00 : 8'h08);
      shortc = (m != 1) && m_ready && (m_code == code);
      rid    = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
      if (shortc) rid = "R5";
      ew[0] = {8'h00, code};
      ew[1] = 16'h0230;
      exp_n = shortc ? 0 : (m == 1) ? 1 : 2;
      etx_fr  = (m == 0) ? 1'b0 : m_tx;
      etx_end = (m != 0);
      clear_log();
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'(m); never_sleep_i = ns;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, "R11 busy after accept", 32'(busy_o), 32'd1);
      if (poke) begin
         @(negedge clk);
         start_i = 1'b1; mode_i = (m == 1) ? 2'b00 : 2'b01;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_done(rid);
      chk(n_fr == exp_n, rid, 32'(n_fr), 32'(exp_n));
      for (int i = 0; i < exp_n && i < 8; i++) begin
         chk(fr_w[i] == ew[i], rid, 32'(fr_w[i]), 32'(ew[i]));
         chk(fr_tx[i] == etx_fr, rid, 32'(fr_tx[i]), 32'(etx_fr));
      end
      chk(tx_en_o == etx_end, rid, 32'(tx_en_o), 32'(etx_end));
      chk(spi_en_o, "R6 spi_en held", 32'(spi_en_o), 32'd1);
      chk(len_err == 0, "R7 sixteen edges", 32'(len_err), 32'd0);
      chk(tim_err == 0, "R8 sck period", 32'(tim_err), 32'd0);
      if (poke) begin
         repeat (60) @(negedge clk);
         chk(!busy_o && n_fr == exp_n, "R11 start during busy ignored", 32'(n_fr), 32'(exp_n));
      end
      m_tx = etx_end;
      if (m == 1) m_ready = 1'b0;
      else begin m_ready = 1'b1; m_code = code; end
   endtask

   task automatic do_poll(input logic [7:0] st, input logic [7:0] ln);
      bit tx_before;
      stat_val = st; len_val = ln;
      tx_before = tx_en_o;
      clear_log();
      @(negedge clk);
      poll_i = 1'b1;
      @(negedge clk);
      poll_i = 1'b0;
      wait_done("R10 poll done");
      chk(n_fr == 2, "R10 frame count", 32'(n_fr), 32'd2);
      chk(fr_w[0] == 16'h8000, "R10 first read", 32'(fr_w[0]), 32'h8000);
      chk(fr_w[1] == 16'h8300, "R10 second read", 32'(fr_w[1]), 32'h8300);
      chk(carrier_o == st[0], "R10 carrier", 32'(carrier_o), 32'(st[0]));
      chk(cable_len_o == ln[4:0], "R10 length", 32'(cable_len_o), 32'(ln[4:0]));
      chk(tx_en_o == tx_before, "R10 tx_en untouched", 32'(tx_en_o), 32'(tx_before));
      chk(oe_err == 0, "R9 mosi released", 32'(oe_err), 32'd0);
      chk(tim_err == 0, "R8 sck period in read", 32'(tim_err), 32'd0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 190000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!tx_en_o && !spi_en_o && ss_n_o && !sck_o && !mosi_o && !mosi_oe_o && !busy_o && !done_o,
          "R1 reset outputs",
          {24'd0, tx_en_o, spi_en_o, ss_n_o, sck_o, mosi_o, mosi_oe_o, busy_o, done_o}, 32'h20);
      rst_n = 1'b1;
      log_on = 1'b1;
      @(negedge clk);
      chk(!spi_en_o && ss_n_o, "R6 spi_en low before request", 32'(spi_en_o), 32'd0);

      // R11: reserved mode ignored
      clear_log();
      start_i = 1'b1; mode_i = 2'b11;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(!busy_o, "R11 reserved mode ignored", 32'(busy_o), 32'd0);
      repeat (80) @(negedge clk);
      chk(n_fr == 0 && !tx_en_o && !spi_en_o, "R11 reserved mode no effect", 32'(n_fr), 32'd0);

      // sweep of all mode and sleep-code transition pairs
      for (int a = 0; a < 3; a++)
         for (int sa = 0; sa < 2; sa++)
            for (int b = 0; b < 3; b++)
               for (int sb = 0; sb < 2; sb++) begin
                  do_op(a, 1'(sa), 1'b0);
                  do_op(b, 1'(sb), 1'b0);
               end

      // R11: a request while busy is ignored
      do_op(1, 1'b0, 1'b0);
      do_op(0, 1'b0, 1'b1);
      do_op(2, 1'b1, 1'b1);

      // R10/R9: polls over all length codes with both carrier values
      for (int l = 0; l < 32; l++)
         do_poll({7'(l * 5), 1'(l[0] ^ l[2])}, {3'(7 - l), 5'(l)});
      do_poll(8'hFE, 8'hE0);
      do_poll(8'h01, 8'h1F);

      finish_run();
   end
endmodule